// File: doc/BRIEF.md
# Memory-Mapped Event Counter Bank

This block is a bank of activity counters for a processor core. Each counter watches one single-cycle event strobe, such as a register file write or a cache access, and adds one in every clock in which that strobe is high while counting is enabled. Every counter is twice as wide as the software bus, so its value is read as a low word followed by a high word.

Software drives the bank through a word-addressed read/write port. A control word at the top of the address space starts, stops or clears all counters at once. Reading the low word of a counter also copies that counter's high word into a shadow register. A following read of any high-word offset returns that shadow, so the two halves always come from the same instant even if the counter moves between the two reads. Each counter has its own registered incrementer and there is no carry logic between counters, so adding counters does not lengthen any timing path.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset the bank holds NUM_CTR counters (36 by default), each 2*BUS_W bits wide (64 by default). All counters read zero and counting is stopped.
- R2: The control word sits at word offset 2**ADDR_W-1. Writing it with bit 0 set starts counting and with bit 1 set stops counting, and stop wins when both bits are set. Reading it returns the running flag in bit 0 and zeros above it.
- R3: Writing the control word with bit 2 set zeroes every counter at that clock edge. Strobes high in that cycle are not counted, and a start bit in the same write is ignored.
- R4: While running, counter i adds exactly one in each clock in which evt[i] is high. Counters are independent, so any number of them may step in the same cycle.
- R5: While stopped, every counter holds its value whatever its strobe does.
- R6: A counter at its all-ones value wraps to zero on its next event and does not saturate.
- R7: Read data is registered. bus_rdata shows the addressed word in the cycle after bus_rd is sampled and holds until the next read. Word offset 2*i returns the low BUS_W bits of counter i.
- R8: A read of offset 2*i copies the high BUS_W bits of counter i into a shadow register. A read of any offset 2*i+1 returns the shadow, not the live high half.
- R9: A read of an offset that is neither a counter word nor the control word returns zero.
- R10: A write to any offset other than the control word changes no counter and no control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | NUM_CTR | Event strobes, bit i feeds counter i |
| bus_wr | input | 1 | Write request, sampled at the rising edge |
| bus_rd | input | 1 | Read request, sampled at the rising edge |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_wdata | input | BUS_W | Write data; only the three command bits are used |
| bus_rdata | output | BUS_W | Registered read data |

## Verification
On every cycle the bound checker checks the counting rules. A counter moves by exactly its strobe while running, holds while stopped and is zero after a clear write. It also checks that start and stop set the running flag, that a low-word read loads the shadow and returns the low half, that a high-word read returns the previous shadow, and that unmapped reads return zero. The bench scenarios show what the checker does not follow end to end. These are the totals built up over long strobe patterns, the coherence of a split read while the counter keeps moving across a half boundary, wrap-around in a narrow instance, strobes dropped in the clear cycle, and a start ignored in a combined clear and start write.

// File: rtl/evb_pkg.sv
package evb_pkg;
    // Bit positions of the command field in the control word
    localparam int CMD_START = 0;
    localparam int CMD_STOP  = 1;
    localparam int CMD_CLR   = 2;
    localparam int CMD_W     = 3;

    typedef struct packed {
        logic run;
    } ctrl_state_t;
endpackage

// File: rtl/evb_ctrl.sv
module evb_ctrl
    import evb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CMD_W-1:0]  cmd,
    output logic              run,
    output logic              clr
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;

    ctrl_state_t st_d, st_q;
    logic        hit;

    always_comb begin
        st_d = st_q;
        hit  = wr && (addr == CTRL_ADDR);
        clr  = hit && cmd[CMD_CLR];
        if (hit) begin
            if (cmd[CMD_START] && !cmd[CMD_CLR]) st_d.run = 1'b1;
            if (cmd[CMD_STOP])                   st_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run = st_q.run;
endmodule

// File: rtl/evb_counter.sv
module evb_counter #(
    parameter int CTR_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             evt,
    output logic [CTR_W-1:0] cnt
);
    typedef struct packed {
        logic [CTR_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)             st_d.cnt = '0;
        else if (en && evt)  st_d.cnt = st_q.cnt + CTR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/evb_rdport.sv
module evb_rdport #(
    parameter int NUM_CTR = 36,
    parameter int BUS_W   = 32,
    parameter int ADDR_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic                              run,
    input  logic [NUM_CTR-1:0][2*BUS_W-1:0]   cnt,
    output logic [BUS_W-1:0]                  rdata,
    output logic [BUS_W-1:0]                  shadow
);
    localparam int                IDX_W     = ADDR_W - 1;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
        logic [BUS_W-1:0] shadow;
    } rd_state_t;

    rd_state_t        st_d, st_q;
    logic [IDX_W-1:0] word_idx;
    logic             hi_half;

    always_comb begin
        st_d     = st_q;
        word_idx = addr[ADDR_W-1:1];
        hi_half  = addr[0];
        if (rd) begin
            st_d.rdata = '0;
            if (addr == CTRL_ADDR) begin
                st_d.rdata = BUS_W'(run);
            end else begin
                for (int i = 0; i < NUM_CTR; i++) begin
                    if (word_idx == IDX_W'(i)) begin
                        if (hi_half) begin
                            st_d.rdata  = st_q.shadow;
                        end else begin
                            st_d.rdata  = cnt[i][BUS_W-1:0];
                            st_d.shadow = cnt[i][2*BUS_W-1:BUS_W];
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata  = st_q.rdata;
    assign shadow = st_q.shadow;
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
    import evb_pkg::*;
#(
    parameter int NUM_CTR = 36,
    parameter int BUS_W   = 32,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTR-1:0] evt,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata
);
    localparam int CTR_W = 2 * BUS_W;

    logic                          run;
    logic                          clr;
    logic [NUM_CTR-1:0][CTR_W-1:0] cnt;
    logic [BUS_W-1:0]              shadow;
    logic                          wdata_unused;

    assign wdata_unused = ^bus_wdata[BUS_W-1:CMD_W];

    evb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (bus_wr),
        .addr (bus_addr),
        .cmd  (bus_wdata[CMD_W-1:0]),
        .run  (run),
        .clr  (clr)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        evb_counter #(.CTR_W(CTR_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (run),
            .clr  (clr),
            .evt  (evt[g]),
            .cnt  (cnt[g])
        );
    end

    evb_rdport #(.NUM_CTR(NUM_CTR), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .run   (run),
        .cnt   (cnt),
        .rdata (bus_rdata),
        .shadow(shadow)
    );
endmodule

// File: rtl/evt_ctr_bank_chk.sv
module evt_ctr_bank_chk
    import evb_pkg::*;
#(
    parameter int NUM_CTR = 36,
    parameter int BUS_W   = 32,
    parameter int ADDR_W  = 8
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [NUM_CTR-1:0]                evt,
    input logic                              bus_wr,
    input logic                              bus_rd,
    input logic [ADDR_W-1:0]                 bus_addr,
    input logic [BUS_W-1:0]                  bus_wdata,
    input logic [BUS_W-1:0]                  bus_rdata,
    input logic                              run,
    input logic [NUM_CTR-1:0][2*BUS_W-1:0]   cnt,
    input logic [BUS_W-1:0]                  shadow
);
    localparam int                CTR_W     = 2 * BUS_W;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;

    logic ctrl_wr, clr_wr, start_wr, stop_wr, is_ctr, unmapped_rd, high_rd;

    assign ctrl_wr     = bus_wr && (bus_addr == CTRL_ADDR);
    assign clr_wr      = ctrl_wr && bus_wdata[CMD_CLR];
    assign stop_wr     = ctrl_wr && bus_wdata[CMD_STOP];
    assign start_wr    = ctrl_wr && bus_wdata[CMD_START] && !bus_wdata[CMD_STOP] && !bus_wdata[CMD_CLR];
    assign is_ctr      = int'(bus_addr) < 2 * NUM_CTR;
    assign unmapped_rd = bus_rd && !is_ctr && (bus_addr != CTRL_ADDR);
    assign high_rd     = bus_rd && is_ctr && bus_addr[0];

    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> run); // R2
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> !run); // R2
    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (cnt == '0)); // R3
    AST_CLR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !run) |=> !run); // R3
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_rd |=> (bus_rdata == '0)); // R9
    AST_HIGH_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        high_rd |=> (bus_rdata == $past(shadow))); // R8

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_chk
        AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (run && !clr_wr) |=> (cnt[g] == $past(cnt[g]) + CTR_W'($past(evt[g])))); // R4
        AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
            (!run && !clr_wr) |=> $stable(cnt[g])); // R5
        AST_WR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && !ctrl_wr && !run) |=> $stable(cnt[g])); // R10
        AST_LOW_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && int'(bus_addr) == 2 * g) |=>
            (shadow == $past(cnt[g][CTR_W-1:BUS_W]) && bus_rdata == $past(cnt[g][BUS_W-1:0]))); // R7
    end
endmodule

bind evt_ctr_bank evt_ctr_bank_chk #(.NUM_CTR(NUM_CTR), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/evt_ctr_bank_tb.sv
`timescale 1ns/1ps
module evt_ctr_bank_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // Default-sized instance
    logic [35:0] b_evt = '0;
    logic        b_wr = 1'b0, b_rd = 1'b0;
    logic [7:0]  b_addr = '0;
    logic [31:0] b_wdata = '0, b_rdata;
    // Narrow instance: 2 counters of 8 bits, 4-bit bus, control at offset 7
    logic [1:0]  s_evt = '0;
    logic        s_wr = 1'b0, s_rd = 1'b0;
    logic [2:0]  s_addr = '0;
    logic [3:0]  s_wdata = '0, s_rdata;

    evt_ctr_bank u_dut (.clk(clk), .rst_n(rst_n), .evt(b_evt), .bus_wr(b_wr), .bus_rd(b_rd),
                        .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(b_rdata));
    evt_ctr_bank #(.NUM_CTR(2), .BUS_W(4), .ADDR_W(3)) u_small (
        .clk(clk), .rst_n(rst_n), .evt(s_evt), .bus_wr(s_wr), .bus_rd(s_rd),
        .bus_addr(s_addr), .bus_wdata(s_wdata), .bus_rdata(s_rdata));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam int BCTRL = 255;
    localparam int SCTRL = 7;
    localparam int NV = 6;
    // columns: counter index, strobe cycles, expected running total
    localparam int VEC [NV][3] = '{'{0, 5, 5}, '{35, 3, 3}, '{7, 1, 1},
                                   '{0, 2, 7}, '{20, 10, 10}, '{35, 4, 7}};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_word(input bit s, input int a, input logic [31:0] d);
        @(negedge clk);
        if (s) begin s_wr = 1'b1; s_addr = 3'(a); s_wdata = d[3:0]; end
        else   begin b_wr = 1'b1; b_addr = 8'(a); b_wdata = d; end
        @(negedge clk);
        s_wr = 1'b0; b_wr = 1'b0;
    endtask

    task automatic rd_word(input bit s, input int a, output logic [31:0] v);
        @(negedge clk);
        if (s) begin s_rd = 1'b1; s_addr = 3'(a); end
        else   begin b_rd = 1'b1; b_addr = 8'(a); end
        @(negedge clk);
        s_rd = 1'b0; b_rd = 1'b0;
        v = s ? 32'(s_rdata) : b_rdata;
    endtask

    task automatic rd_ctr(input int i, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd_word(1'b0, 2 * i, lo);
        rd_word(1'b0, 2 * i + 1, hi);
        v = {hi, lo};
    endtask

    task automatic pulse(input bit s, input int i, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (s) s_evt = 2'(1) << i;
            else   b_evt = 36'(1) << i;
        end
        @(negedge clk);
        s_evt = '0; b_evt = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        logic [31:0] w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_ctr(0, v);  check("R1 ctr0 after reset", v, 64'd0);
        rd_ctr(35, v); check("R1 ctr35 after reset", v, 64'd0);
        rd_word(1'b0, BCTRL, w); check("R2 stopped after reset", w, 32'd0);

        // R2: start (bit 0)
        wr_word(1'b0, BCTRL, 32'h1);
        rd_word(1'b0, BCTRL, w); check("R2 running after start", w, 32'd1);

        // R4/R7: table of strobe patterns
        for (int t = 0; t < NV; t++) begin
            pulse(1'b0, VEC[t][0], VEC[t][1]);
            rd_ctr(VEC[t][0], v);
            check("R4 table total", v, 64'(VEC[t][2]));
        end

        // R4: all strobes together for 3 cycles
        for (int k = 0; k < 3; k++) begin @(negedge clk); b_evt = '1; end
        @(negedge clk); b_evt = '0;
        rd_ctr(0, v);  check("R4 all strobes ctr0", v, 64'd10);
        rd_ctr(3, v);  check("R4 all strobes ctr3", v, 64'd3);
        rd_ctr(20, v); check("R4 all strobes ctr20", v, 64'd13);

        // R2/R5: stop (bit 1), then strobes are held off
        wr_word(1'b0, BCTRL, 32'h2);
        rd_word(1'b0, BCTRL, w); check("R2 stopped after stop", w, 32'd0);
        pulse(1'b0, 0, 4);
        rd_ctr(0, v); check("R5 ctr0 held while stopped", v, 64'd10);

        // R10: write to a counter word is ignored
        wr_word(1'b0, 0, 32'hDEAD);
        wr_word(1'b0, 41, 32'hBEEF);
        rd_ctr(0, v);  check("R10 ctr0 unchanged by write", v, 64'd10);
        rd_ctr(20, v); check("R10 ctr20 unchanged by write", v, 64'd13);
        rd_word(1'b0, BCTRL, w); check("R10 control unchanged", w, 32'd0);

        // R9: unmapped offsets read zero after a nonzero read
        rd_word(1'b0, 0, w); check("R7 ctr0 low word", w, 32'd10);
        rd_word(1'b0, 72, w); check("R9 offset 72 zero", w, 32'd0);
        rd_word(1'b0, 0, w);
        rd_word(1'b0, 254, w); check("R9 offset 254 zero", w, 32'd0);

        // R2: start and stop together -> stop wins
        wr_word(1'b0, BCTRL, 32'h3);
        rd_word(1'b0, BCTRL, w); check("R2 stop wins over start", w, 32'd0);

        // R3: clear while running, strobe in the clear cycle is dropped
        wr_word(1'b0, BCTRL, 32'h1);
        @(negedge clk);
        b_wr = 1'b1; b_addr = 8'(BCTRL); b_wdata = 32'h4; b_evt = 36'(1) << 1;
        @(negedge clk); b_wr = 1'b0;
        @(negedge clk);
        @(negedge clk); b_evt = '0;
        rd_ctr(1, v);  check("R3 strobe in clear cycle dropped", v, 64'd2);
        rd_ctr(0, v);  check("R3 ctr0 cleared", v, 64'd0);
        rd_ctr(35, v); check("R3 ctr35 cleared", v, 64'd0);
        rd_word(1'b0, BCTRL, w); check("R3 clear keeps running", w, 32'd1);

        // R3: clear with start while stopped -> start ignored
        wr_word(1'b0, BCTRL, 32'h2);
        wr_word(1'b0, BCTRL, 32'h5);
        rd_word(1'b0, BCTRL, w); check("R3 start ignored with clear", w, 32'd0);
        rd_ctr(1, v); check("R3 ctr1 cleared", v, 64'd0);

        // R8/R6: narrow instance, split read and wrap
        wr_word(1'b1, SCTRL, 32'h1);
        pulse(1'b1, 0, 14);
        rd_word(1'b1, 0, w); check("R7 narrow low 0x0E", w, 32'hE);
        pulse(1'b1, 0, 3);
        rd_word(1'b1, 1, w); check("R8 high half from shadow", w, 32'h0);
        rd_word(1'b1, 0, w); check("R8 low after move", w, 32'h1);
        rd_word(1'b1, 1, w); check("R8 high after new latch", w, 32'h1);
        pulse(1'b1, 0, 239);
        rd_word(1'b1, 0, w); check("R6 wrapped low", w, 32'h0);
        rd_word(1'b1, 1, w); check("R6 wrapped high", w, 32'h0);
        pulse(1'b1, 0, 1);
        rd_word(1'b1, 0, w); check("R6 counts after wrap", w, 32'h1);
        rd_word(1'b1, 5, w); check("R9 narrow unmapped zero", w, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule